// File: doc/BRIEF.md
# Security-Banked Interrupt Distributor Register File

This block holds the configuration state of a small interrupt distributor. That state is a global control word with two group enables. For each interrupt source it also holds a security group bit, an enable bit, an 8-bit priority and an 8-bit CPU target mask. Software reaches the state through a simple slave bus. Each access on that bus carries a secure attribute. The state is also presented continuously on output vectors, which feed the arbitration logic downstream.

A Non-secure access never sees or changes the settings of a Secure interrupt. The global control word presents a different bit layout to Non-secure accesses, so that they can only reach the Group 1 enable. The security group of each interrupt can be configured by Secure accesses only. Once an interrupt is moved into Group 1, Non-secure software can manage its enable, priority and target in the normal way.

The bus is word addressed, and an access completes in a single beat. Read data appears on `bus_rdata` one clock after the read beat and holds until the next read. The number of sources is `NUM_IRQ`, which must be a multiple of 32 and at most 256.

Top module: `irq_dist_regs`

## Requirements
- R1: A Secure access to word 0 (control) sees bit 0 as the Group 0 enable and bit 1 as the Group 1 enable, for both reads and writes; all other bits read as zero.
- R2: A Non-secure access to word 0 sees bit 0 as the Group 1 enable. Bit 1 and all higher bits read as zero and are ignored on write. A Non-secure write never changes the Group 0 enable, so after a Secure write of 3 a Non-secure read returns 1.
- R3: Word 16+k holds the group bits, with bit j belonging to interrupt 32k+j; a value of 1 means Non-secure (Group 1). Secure accesses read and write this word. Non-secure accesses read zero, and their writes have no effect.
- R4: A write to word 32+k (set-enable) sets the enable of interrupt 32k+j for every bit j written as 1. A write to word 48+k (clear-enable) clears those enables. Bits written as 0 leave the enables unchanged. Reads of either word return the current enables.
- R5: Word 64+k holds the priorities and word 128+k holds the targets. Byte lane n (bits 8n+7..8n) of each word belongs to interrupt 4k+n.
- R6: A Non-secure access to an interrupt whose group bit is 0 reads zero in that interrupt's bit or byte lane of the enable, priority and target words, and its writes leave those fields unchanged. This applies independently to each bit and each lane.
- R7: A Non-secure access to a Group 1 interrupt, and any Secure access, reads and writes the interrupt's enable, priority and target fields without restriction.
- R8: After reset the group enables, all group bits, all enables, all priorities and all targets are zero.
- R9: Read data appears on `bus_rdata` in the cycle after the read beat. Unmapped words, and words beyond the configured `NUM_IRQ`, read as zero; writes to them have no effect.
- R10: The output ports show the stored state at all times: `irq_group`, `irq_enable`, `irq_prio` lane i and `irq_target` lane i for interrupt i, and the two group enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access beat valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | 1 = Secure access, 0 = Non-secure access |
| bus_rdata | output | 32 | Read data, valid the cycle after a read beat |
| grp0_enable | output | 1 | Group 0 enable |
| grp1_enable | output | 1 | Group 1 enable |
| irq_enable | output | NUM_IRQ | Per-interrupt enable |
| irq_group | output | NUM_IRQ | Per-interrupt group bit (1 = Non-secure) |
| irq_prio | output | 8*NUM_IRQ | Priority byte per interrupt |
| irq_target | output | 8*NUM_IRQ | Target byte per interrupt |

## Verification
The hardest state to reach is a mixed group pattern. In that state, one Non-secure word write lands partly on Secure lanes and partly on Non-secure lanes. The effect of such a write is only visible when the word is read back from both security views. The bench first gives the interrupts an irregular group pattern through a Secure write. It then sweeps Non-secure writes of dense, lane-distinct data over every mapped word. After every phase, it reads all 256 word addresses in both security views and compares them with an arithmetic model. The bench also toggles interrupts between the groups, so that it can show that Non-secure writes made while an interrupt was Secure left no trace.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_GROUP, RG_SETEN, RG_CLREN, RG_PRIO, RG_TARGET
  } region_e;

  typedef struct packed {
    region_e    region;
    logic [5:0] idx;
  } decode_t;

  // Word map: 0 control, 16..23 group, 32..39 set-enable, 48..55 clear-enable,
  // 64..127 priority, 128..191 target.
  function automatic decode_t decode_word(input logic [7:0] w);
    decode_t d;
    d.region = RG_NONE;
    d.idx    = '0;
    if (w == 8'd0) begin
      d.region = RG_CTRL;
    end else if (w[7:3] == 5'b00010) begin
      d.region = RG_GROUP;
      d.idx    = {3'b000, w[2:0]};
    end else if (w[7:3] == 5'b00100) begin
      d.region = RG_SETEN;
      d.idx    = {3'b000, w[2:0]};
    end else if (w[7:3] == 5'b00110) begin
      d.region = RG_CLREN;
      d.idx    = {3'b000, w[2:0]};
    end else if (w[7:6] == 2'b01) begin
      d.region = RG_PRIO;
      d.idx    = w[5:0];
    end else if (w[7:6] == 2'b10) begin
      d.region = RG_TARGET;
      d.idx    = w[5:0];
    end
    return d;
  endfunction

endpackage

// File: rtl/irq_dist_ctrl.sv
module irq_dist_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       secure,
  input  logic [1:0] wbits,
  output logic       grp0_en,
  output logic       grp1_en,
  output logic [1:0] rd_bits
);

  logic g0_q, g1_q, g0_d, g1_d;

  always_comb begin
    g0_d = g0_q;
    g1_d = g1_q;
    if (wr_en) begin
      if (secure) begin
        g0_d = wbits[0];
        g1_d = wbits[1];
      end else begin
        g1_d = wbits[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g0_q <= 1'b0;
      g1_q <= 1'b0;
    end else if (wr_en) begin
      g0_q <= g0_d;
      g1_q <= g1_d;
    end
  end

  assign grp0_en = g0_q;
  assign grp1_en = g1_q;
  assign rd_bits = secure ? {g1_q, g0_q} : {1'b0, g1_q};

  // R2
  ns_keeps_grp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure) |=> (grp0_en == $past(grp0_en)))
    else $error("Non-secure write altered Group 0 enable");

  // R2
  ns_bit0_to_grp1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure) |=> (grp1_en == $past(wbits[0])))
    else $error("Non-secure bit 0 did not reach Group 1 enable");

  // R1
  s_both_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && secure) |=> ({grp1_en, grp0_en} == $past(wbits)))
    else $error("Secure control write not stored");

endmodule

// File: rtl/irq_dist_src.sv
module irq_dist_src
  import irq_dist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              secure,
  input  logic              grp_we,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              wbit,
  input  logic              prio_we,
  input  logic              tgt_we,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              group,
  output logic              enable,
  output logic [BYTE_W-1:0] prio,
  output logic [BYTE_W-1:0] target,
  output logic              acc_ok
);

  logic              grp_q, grp_d, en_q, en_d;
  logic [BYTE_W-1:0] prio_q, prio_d, tgt_q, tgt_d;
  logic              load;

  assign acc_ok = secure | grp_q;

  always_comb begin
    grp_d  = grp_q;
    en_d   = en_q;
    prio_d = prio_q;
    tgt_d  = tgt_q;
    if (grp_we && secure) grp_d = wbit;
    if (acc_ok) begin
      if (set_we && wbit)      en_d = 1'b1;
      else if (clr_we && wbit) en_d = 1'b0;
      if (prio_we) prio_d = wbyte;
      if (tgt_we)  tgt_d  = wbyte;
    end
  end

  assign load = grp_we | set_we | clr_we | prio_we | tgt_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= 1'b0;
      en_q   <= 1'b0;
      prio_q <= '0;
      tgt_q  <= '0;
    end else if (load) begin
      grp_q  <= grp_d;
      en_q   <= en_d;
      prio_q <= prio_d;
      tgt_q  <= tgt_d;
    end
  end

  assign group  = grp_q;
  assign enable = en_q;
  assign prio   = prio_q;
  assign target = tgt_q;

  // R6
  ns_secure_irq_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!secure && !grp_q && (set_we || clr_we || prio_we || tgt_we))
      |=> ($stable(en_q) && $stable(prio_q) && $stable(tgt_q)))
    else $error("Non-secure write changed a Secure interrupt");

  // R3
  ns_group_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_we && !secure) |=> $stable(grp_q))
    else $error("Non-secure write changed a group bit");

  // R4
  set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && wbit && (secure || grp_q)) |=> en_q)
    else $error("Set-enable did not set");

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [7:0]                bus_word_addr,
  input  logic [31:0]               bus_wdata,
  input  logic                      bus_secure,
  output logic [31:0]               bus_rdata,
  output logic                      grp0_enable,
  output logic                      grp1_enable,
  output logic [NUM_IRQ-1:0]        irq_enable,
  output logic [NUM_IRQ-1:0]        irq_group,
  output logic [NUM_IRQ*BYTE_W-1:0] irq_prio,
  output logic [NUM_IRQ*BYTE_W-1:0] irq_target
);

  localparam int BITS_PER_WORD  = 32;
  localparam int LANES_PER_WORD = 32 / BYTE_W;

  decode_t     dec;
  logic        wr, rd;
  logic [1:0]  ctrl_rd;
  logic [31:0] rd_d, rdata_q;

  logic              grp_v  [NUM_IRQ];
  logic              en_v   [NUM_IRQ];
  logic              ok_v   [NUM_IRQ];
  logic [BYTE_W-1:0] prio_v [NUM_IRQ];
  logic [BYTE_W-1:0] tgt_v  [NUM_IRQ];

  assign dec = decode_word(bus_word_addr);
  assign wr  = bus_valid & bus_write;
  assign rd  = bus_valid & ~bus_write;

  irq_dist_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr && dec.region == RG_CTRL),
    .secure  (bus_secure),
    .wbits   (bus_wdata[1:0]),
    .grp0_en (grp0_enable),
    .grp1_en (grp1_enable),
    .rd_bits (ctrl_rd)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    localparam int BW = i / BITS_PER_WORD;
    localparam int BB = i % BITS_PER_WORD;
    localparam int YW = i / LANES_PER_WORD;
    localparam int YL = i % LANES_PER_WORD;
    logic bit_hit, lane_hit;
    assign bit_hit  = (dec.idx == 6'(BW));
    assign lane_hit = (dec.idx == 6'(YW));

    irq_dist_src u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .secure  (bus_secure),
      .grp_we  (wr && dec.region == RG_GROUP  && bit_hit),
      .set_we  (wr && dec.region == RG_SETEN  && bit_hit),
      .clr_we  (wr && dec.region == RG_CLREN  && bit_hit),
      .wbit    (bus_wdata[BB]),
      .prio_we (wr && dec.region == RG_PRIO   && lane_hit),
      .tgt_we  (wr && dec.region == RG_TARGET && lane_hit),
      .wbyte   (bus_wdata[YL*BYTE_W +: BYTE_W]),
      .group   (grp_v[i]),
      .enable  (en_v[i]),
      .prio    (prio_v[i]),
      .target  (tgt_v[i]),
      .acc_ok  (ok_v[i])
    );

    assign irq_group[i]                  = grp_v[i];
    assign irq_enable[i]                 = en_v[i];
    assign irq_prio[i*BYTE_W +: BYTE_W]   = prio_v[i];
    assign irq_target[i*BYTE_W +: BYTE_W] = tgt_v[i];
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (dec.idx == 6'(i / BITS_PER_WORD)) begin
        if (dec.region == RG_GROUP && bus_secure)
          rd_d[i % BITS_PER_WORD] = grp_v[i];
        if ((dec.region == RG_SETEN || dec.region == RG_CLREN) && ok_v[i])
          rd_d[i % BITS_PER_WORD] = en_v[i];
      end
      if (dec.idx == 6'(i / LANES_PER_WORD) && ok_v[i]) begin
        if (dec.region == RG_PRIO)
          rd_d[(i % LANES_PER_WORD)*BYTE_W +: BYTE_W] = prio_v[i];
        if (dec.region == RG_TARGET)
          rd_d[(i % LANES_PER_WORD)*BYTE_W +: BYTE_W] = tgt_v[i];
      end
    end
    if (dec.region == RG_CTRL) rd_d[1:0] = ctrl_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;

  // R3
  ns_group_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !bus_secure && dec.region == RG_GROUP) |=> (bus_rdata == '0))
    else $error("Non-secure group read not zero");

  // R9
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && dec.region == RG_NONE) |=> (bus_rdata == '0))
    else $error("Unmapped read not zero");

  // R2
  ns_ctrl_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !bus_secure && dec.region == RG_CTRL) |=> (bus_rdata[31:1] == '0))
    else $error("Non-secure control read has upper bits set");

endmodule

// File: tb/irq_dist_regs_tb.sv
module irq_dist_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_valid = 1'b0, bus_write = 1'b0, bus_secure = 1'b0;
  logic [7:0]      bus_word_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            grp0_enable, grp1_enable;
  logic [N-1:0]    irq_enable, irq_group;
  logic [N*8-1:0]  irq_prio, irq_target;

  int checks = 0;
  int errors = 0;

  bit       m_g0, m_g1;
  bit       m_grp [N];
  bit       m_en  [N];
  bit [7:0] m_pr  [N];
  bit [7:0] m_tg  [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dist_regs #(.NUM_IRQ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_word_addr(bus_word_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
    .bus_rdata(bus_rdata), .grp0_enable(grp0_enable), .grp1_enable(grp1_enable),
    .irq_enable(irq_enable), .irq_group(irq_group), .irq_prio(irq_prio),
    .irq_target(irq_target)
  );

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit ok(input int i, input bit sec);
    return sec || m_grp[i];
  endfunction

  function automatic logic [31:0] exp_read(input int w, input bit sec);
    logic [31:0] r = '0;
    if (w == 0) r = sec ? {30'd0, m_g1, m_g0} : {31'd0, m_g1};
    else if (w >= 16 && w < 24) begin
      for (int j = 0; j < 32; j++) begin
        if ((w-16)*32+j < N && sec) r[j] = m_grp[(w-16)*32+j];
      end
    end else if ((w >= 32 && w < 40) || (w >= 48 && w < 56)) begin
      for (int j = 0; j < 32; j++) begin
        int i = (w % 16)*32 + j;
        if (i < N && ok(i, sec)) r[j] = m_en[i];
      end
    end else if (w >= 64 && w < 192) begin
      for (int n = 0; n < 4; n++) begin
        int i = ((w % 64))*4 + n;
        if (i < N && ok(i, sec)) r[n*8 +: 8] = (w < 128) ? m_pr[i] : m_tg[i];
      end
    end
    return r;
  endfunction

  function automatic void model_write(input int w, input logic [31:0] d, input bit sec);
    if (w == 0) begin
      if (sec) begin m_g0 = d[0]; m_g1 = d[1]; end
      else m_g1 = d[0];
    end else if (w >= 16 && w < 24) begin
      for (int j = 0; j < 32; j++) begin
        if ((w-16)*32+j < N && sec) m_grp[(w-16)*32+j] = d[j];
      end
    end else if ((w >= 32 && w < 40) || (w >= 48 && w < 56)) begin
      for (int j = 0; j < 32; j++) begin
        int i = (w % 16)*32 + j;
        if (i < N && ok(i, sec) && d[j]) m_en[i] = (w < 48);
      end
    end else if (w >= 64 && w < 192) begin
      for (int n = 0; n < 4; n++) begin
        int i = (w % 64)*4 + n;
        if (i < N && ok(i, sec)) begin
          if (w < 128) m_pr[i] = d[n*8 +: 8];
          else         m_tg[i] = d[n*8 +: 8];
        end
      end
    end
  endfunction

  task automatic bus_wr(input int w, input logic [31:0] d, input bit sec);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_word_addr = 8'(w);
    bus_wdata = d; bus_secure = sec;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    model_write(w, d, sec);
  endtask

  task automatic bus_rd(input int w, input bit sec, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_word_addr = 8'(w); bus_secure = sec;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  function automatic string tag_for(input int w, input bit sec);
    if (w == 0) return sec ? "R1" : "R2";
    if (w >= 16 && w < 24) return "R3";
    if (w >= 32 && w < 56) return sec ? "R4 R7" : "R4 R6 R7";
    if (w >= 64 && w < 192) return sec ? "R5 R7" : "R5 R6 R7";
    return "R9";
  endfunction

  task automatic sweep(input string phase);
    logic [31:0] d;
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 256; w++) begin
        bus_rd(w, s[0], d);
        check({phase, " ", tag_for(w, s[0])}, 256'(d), 256'(exp_read(w, s[0])));
      end
    end
  endtask

  task automatic check_outputs(input string tag);
    logic [N-1:0] eg, ee;
    logic [N*8-1:0] ep, et;
    for (int i = 0; i < N; i++) begin
      eg[i] = m_grp[i]; ee[i] = m_en[i];
      ep[i*8 +: 8] = m_pr[i]; et[i*8 +: 8] = m_tg[i];
    end
    check({tag, " R10 group"},  256'(irq_group), 256'(eg));
    check({tag, " R10 enable"}, 256'(irq_enable), 256'(ee));
    check({tag, " R10 prio"},   256'(irq_prio), 256'(ep));
    check({tag, " R10 target"}, 256'(irq_target), 256'(et));
    check({tag, " R10 ctrl"},   256'({grp1_enable, grp0_enable}), 256'({m_g1, m_g0}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    m_g0 = 0; m_g1 = 0;
    for (int i = 0; i < N; i++) begin
      m_grp[i] = 0; m_en[i] = 0; m_pr[i] = 0; m_tg[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    check_outputs("R8 reset");
    sweep("R8 reset");

    // R6: Non-secure writes to an all-Secure configuration are dropped
    for (int w = 0; w < 192; w++) bus_wr(w, 32'hFFFF_FFFF, 1'b0);
    check_outputs("R6 all-secure");
    sweep("R6 all-secure");

    // R3 R6 R7: mixed groups, then Non-secure writes over all fields
    bus_wr(16, 32'hA5A5_3C0F, 1'b1);
    for (int k = 0; k < 8; k++) begin
      bus_wr(64 + k,  (32'(k) * 32'h1111_1111) ^ 32'h1357_9BDF, 1'b0);
      bus_wr(128 + k, (32'(k) * 32'h0101_0101) ^ 32'hF0E1_D2C3, 1'b0);
    end
    bus_wr(32, 32'hFFFF_FFFF, 1'b0);
    bus_wr(48, 32'h0F0F_0F0F, 1'b0);
    check_outputs("R6 R7 mixed");
    sweep("R6 R7 mixed");

    // R7: Secure writes reach every interrupt
    for (int k = 0; k < 8; k++) begin
      bus_wr(64 + k,  32'h8040_2010 + 32'(k) * 32'h0203_0405, 1'b1);
      bus_wr(128 + k, 32'h0102_0408 ^ (32'(k) << 3), 1'b1);
    end
    bus_wr(32, 32'h00FF_00FF, 1'b1);
    bus_wr(48, 32'h000F_0000, 1'b1);
    check_outputs("R7 secure");
    sweep("R7 secure");

    // R1 R2 control banking
    bus_wr(0, 32'h3, 1'b1);
    bus_rd(0, 1'b1, d); check("R1 secure ctrl read", 256'(d), 256'(32'h3));
    bus_rd(0, 1'b0, d); check("R2 ns ctrl read after 0x3", 256'(d), 256'(32'h1));
    bus_wr(0, 32'h0, 1'b0);
    check("R2 ns clear keeps grp0", 256'({grp1_enable, grp0_enable}), 256'(2'b01));
    bus_wr(0, 32'h0, 1'b1);
    bus_wr(0, 32'h3, 1'b0);
    check("R2 ns write 0x3 no grp0", 256'({grp1_enable, grp0_enable}), 256'(2'b10));
    bus_rd(0, 1'b1, d); check("R2 secure view after ns write", 256'(d), 256'(32'h2));

    // R6: regroup to Secure, Non-secure clears dropped, then expose again
    bus_wr(16, 32'h0, 1'b1);
    bus_wr(48, 32'hFFFF_FFFF, 1'b0);
    bus_wr(16, 32'h0000_0000 | 32'hFFFF_0000, 1'b0);
    bus_wr(16, 32'hFFFF_FFFF, 1'b1);
    check_outputs("R6 regroup");
    sweep("R6 regroup");

    // R9: one-cycle latency, held between reads
    bus_rd(32, 1'b1, d);
    @(negedge clk);
    check("R9 rdata held", 256'(bus_rdata), 256'(exp_read(32, 1'b1)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule